// File: doc/BRIEF.md
# Reset and Mode-Select Pin Controller

This block owns two shared package pins of a small microcontroller and decides, cycle by cycle, which function each pin serves. The first pin (pin A) is a general-purpose input, an external active-low reset input, or a timer capture input. The second pin (pin B) is either the debug/mode-select line or is released to its alternate timer and port functions. The block also generates the internal reset from three sources: power-on, a debug force-reset request and the external reset pin. When a power-on or debug force reset ends, it latches the operating mode from the level on pin B.

Software controls two enable bits through a simple write strobe. The reset-pin enable can only be set. Once set, it stays set until the next power-on reset. The debug-pin enable is forced on by every reset and must be cleared by software to free pin B. Pull-ups follow the selected functions automatically. The external reset input passes through a two-flop synchronizer before it raises a reset request. All functional outputs are registered.

Top module: `rstmode_pin_ctrl`

## Requirements
- R1: After a power-on reset with pin B high, `mode_bg_o` is 0 (normal mode), `pin_a_func_o` is 0 (general-purpose input) and `pin_a_pullup_o` is 0.
- R2: Pin A function codes are 0 = general-purpose input, 1 = reset input, 2 = timer capture. Writing 1 to the reset-pin enable outside reset gives code 1 and pull-up 1 two clocks after the write edge.
- R3: The reset-pin enable is sticky. A write of 0 leaves pin A at code 1, and only `por_i` clears the enable.
- R4: While pin A is the reset input, a low level on pin A raises `ext_rst_req_o` three clocks later and then starts an internal reset. While pin A is not the reset input, a low level on pin A raises neither `ext_rst_req_o` nor `sys_rst_o`.
- R5: A power-on reset with pin B low ends with `mode_bg_o` = 1 and pin A defaulting to code 1 with pull-up on.
- R6: With the reset-pin enable clear, a timer capture enable of 1 selects code 2. With the reset-pin enable set, code 1 wins over capture.
- R7: Every reset source sets the debug-pin enable. While that enable is set, `pin_b_dbg_o` and `pin_b_pullup_o` are 1. A write of 0 outside reset releases pin B (both 0).
- R8: At the end of an internal reset caused by power-on or debug force reset, `mode_bg_o` takes the inverse of the pin B level (low gives background mode = 1).
- R9: An internal reset caused only by the external pin keeps the previously latched `mode_bg_o`.
- R10: `sys_rst_o` stays high for RST_CYCLES clocks after the last cycle in which a reset trigger was present.
- R11: Register writes made while `sys_rst_o` is high have no effect.
- R12: A debug force reset into background mode leaves the reset-pin enable unchanged. The reset-pin default applies only after a power-on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, synchronous, active high |
| dbg_force_rst_i | input | 1 | Debug force-reset request, one cycle or longer |
| cfg_wr_i | input | 1 | Write strobe for the two enable bits |
| cfg_rstpin_en_i | input | 1 | Write data: reset-pin enable (set-only) |
| cfg_dbgpin_en_i | input | 1 | Write data: debug-pin enable |
| tmr_capture_en_i | input | 1 | Timer channel configured for input capture |
| pin_a_i | input | 1 | Sampled level of pin A |
| pin_b_i | input | 1 | Sampled level of pin B |
| pin_a_func_o | output | 2 | Pin A function code (0 GPIO, 1 reset, 2 capture) |
| pin_a_pullup_o | output | 1 | Pin A pull-up enable |
| pin_b_dbg_o | output | 1 | Pin B serves debug/mode-select (0: alternate functions) |
| pin_b_pullup_o | output | 1 | Pin B pull-up enable |
| ext_rst_req_o | output | 1 | Synchronized external reset request |
| sys_rst_o | output | 1 | Internal reset, active high |
| mode_bg_o | output | 1 | Latched operating mode (1 = background) |

## Verification
The hardest situation to reach is a reset whose cause must be remembered across overlapping triggers. An example is an external-pin reset that arrives after a background-mode power-on. It must not resample pin B even though pin B has since gone high. The bench reaches this state in steps. It first boots into background mode, which also enables the reset pin by default. It then raises pin B and pulls pin A low long enough for the synchronizer to pass the level. A sweep over reset source, pin B level, capture enable and the prior enable state then checks the default rules for every combination.

// File: rtl/rmc_pkg.sv
package rmc_pkg;
  typedef enum logic [1:0] {
    PA_GPIO    = 2'd0,
    PA_RESET   = 2'd1,
    PA_CAPTURE = 2'd2
  } pa_func_e;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_POR   = 2'd1,
    CAUSE_FORCE = 2'd2,
    CAUSE_EXT   = 2'd3
  } rst_cause_e;
endpackage

// File: rtl/rmc_sync.sv
module rmc_sync #(
  parameter int  STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst_i) chain_q[s] <= RESET_VAL;
        else if (s == 0) chain_q[s] <= d_i;
        else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rmc_rst_seq.sv
module rmc_rst_seq
  import rmc_pkg::*;
#(
  parameter int RST_CYCLES = 8
) (
  input  logic clk,
  input  logic por_i,
  input  logic force_i,
  input  logic ext_i,
  input  logic pin_b_i,
  output logic sys_rst_o,
  output logic mode_bg_o,
  output logic sample_por_bg_o
);
  localparam int CW = $clog2(RST_CYCLES + 1);

  logic [CW-1:0] cnt_q;
  rst_cause_e    cause_q;
  logic          mode_q;
  logic          trig;
  logic          last_cycle;

  assign trig       = force_i || ext_i;
  assign last_cycle = (cnt_q == CW'(1)) && !trig;

  always_ff @(posedge clk) begin
    if (por_i) begin
      cnt_q   <= CW'(RST_CYCLES);
      cause_q <= CAUSE_POR;
      mode_q  <= 1'b0;
    end else if (trig) begin
      cnt_q <= CW'(RST_CYCLES);
      if (force_i && cause_q != CAUSE_POR) cause_q <= CAUSE_FORCE;
      else if (cause_q == CAUSE_NONE)      cause_q <= CAUSE_EXT;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        if (cause_q == CAUSE_POR || cause_q == CAUSE_FORCE) mode_q <= ~pin_b_i;
        cause_q <= CAUSE_NONE;
      end
    end
  end

  assign sys_rst_o       = (cnt_q != '0);
  assign mode_bg_o       = mode_q;
  assign sample_por_bg_o = last_cycle && (cause_q == CAUSE_POR) && !pin_b_i;

  AST_MODE_STABLE_OUTSIDE_RST: assert property (@(posedge clk) disable iff (por_i)
    !sys_rst_o |=> $stable(mode_bg_o)); // R9
  AST_TRIG_STARTS_RST: assert property (@(posedge clk) disable iff (por_i)
    trig |=> sys_rst_o); // R10
endmodule

// File: rtl/rmc_cfg.sv
module rmc_cfg (
  input  logic clk,
  input  logic por_i,
  input  logic sys_rst_i,
  input  logic sample_por_bg_i,
  input  logic wr_i,
  input  logic wr_rstpin_i,
  input  logic wr_dbgpin_i,
  output logic rstpin_en_o,
  output logic dbgpin_en_o
);
  logic rst_en_q;
  logic dbg_en_q;

  always_ff @(posedge clk) begin
    if (por_i) begin
      rst_en_q <= 1'b0;
      dbg_en_q <= 1'b1;
    end else if (sys_rst_i) begin
      dbg_en_q <= 1'b1;
      if (sample_por_bg_i) rst_en_q <= 1'b1;
    end else if (wr_i) begin
      rst_en_q <= rst_en_q | wr_rstpin_i;
      dbg_en_q <= wr_dbgpin_i;
    end
  end

  assign rstpin_en_o = rst_en_q;
  assign dbgpin_en_o = dbg_en_q;

  AST_RSTPIN_STICKY: assert property (@(posedge clk) disable iff (por_i)
    rst_en_q |=> rst_en_q); // R3
  AST_DBG_SET_BY_RST: assert property (@(posedge clk) disable iff (por_i)
    sys_rst_i |=> dbg_en_q); // R7
  AST_NO_WRITE_IN_RST: assert property (@(posedge clk) disable iff (por_i)
    (sys_rst_i && !sample_por_bg_i && !rst_en_q) |=> !rst_en_q); // R11
endmodule

// File: rtl/rstmode_pin_ctrl.sv
module rstmode_pin_ctrl
  import rmc_pkg::*;
#(
  parameter int RST_CYCLES  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       por_i,
  input  logic       dbg_force_rst_i,
  input  logic       cfg_wr_i,
  input  logic       cfg_rstpin_en_i,
  input  logic       cfg_dbgpin_en_i,
  input  logic       tmr_capture_en_i,
  input  logic       pin_a_i,
  input  logic       pin_b_i,
  output logic [1:0] pin_a_func_o,
  output logic       pin_a_pullup_o,
  output logic       pin_b_dbg_o,
  output logic       pin_b_pullup_o,
  output logic       ext_rst_req_o,
  output logic       sys_rst_o,
  output logic       mode_bg_o
);
  logic     pin_a_sync;
  logic     ext_req_q;
  logic     sys_rst;
  logic     sample_por_bg;
  logic     rst_en;
  logic     dbg_en;
  pa_func_e pa_func_d;
  pa_func_e pa_func_q;
  logic     pa_pu_q;
  logic     pb_dbg_q;
  logic     pb_pu_q;

  rmc_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_i (por_i),
    .d_i   (pin_a_i),
    .q_o   (pin_a_sync)
  );

  rmc_rst_seq #(.RST_CYCLES(RST_CYCLES)) u_seq (
    .clk             (clk),
    .por_i           (por_i),
    .force_i         (dbg_force_rst_i),
    .ext_i           (ext_req_q),
    .pin_b_i         (pin_b_i),
    .sys_rst_o       (sys_rst),
    .mode_bg_o       (mode_bg_o),
    .sample_por_bg_o (sample_por_bg)
  );

  rmc_cfg u_cfg (
    .clk             (clk),
    .por_i           (por_i),
    .sys_rst_i       (sys_rst),
    .sample_por_bg_i (sample_por_bg),
    .wr_i            (cfg_wr_i),
    .wr_rstpin_i     (cfg_rstpin_en_i),
    .wr_dbgpin_i     (cfg_dbgpin_en_i),
    .rstpin_en_o     (rst_en),
    .dbgpin_en_o     (dbg_en)
  );

  always_comb begin
    if (rst_en)                pa_func_d = PA_RESET;
    else if (tmr_capture_en_i) pa_func_d = PA_CAPTURE;
    else                       pa_func_d = PA_GPIO;
  end

  always_ff @(posedge clk) begin
    if (por_i) begin
      ext_req_q <= 1'b0;
      pa_func_q <= PA_GPIO;
      pa_pu_q   <= 1'b0;
      pb_dbg_q  <= 1'b1;
      pb_pu_q   <= 1'b1;
    end else begin
      ext_req_q <= rst_en && !pin_a_sync;
      pa_func_q <= pa_func_d;
      pa_pu_q   <= rst_en;
      pb_dbg_q  <= dbg_en;
      pb_pu_q   <= dbg_en;
    end
  end

  assign pin_a_func_o   = pa_func_q;
  assign pin_a_pullup_o = pa_pu_q;
  assign pin_b_dbg_o    = pb_dbg_q;
  assign pin_b_pullup_o = pb_pu_q;
  assign ext_rst_req_o  = ext_req_q;
  assign sys_rst_o      = sys_rst;

  AST_EXT_REQ_NEEDS_RSTPIN: assert property (@(posedge clk) disable iff (por_i)
    ext_rst_req_o |-> pin_a_pullup_o); // R4
  AST_PA_FUNC_LEGAL: assert property (@(posedge clk) disable iff (por_i)
    pin_a_func_o != 2'd3); // R2
endmodule

// File: tb/sim_rstmode_pin_ctrl.sv
module sim_rstmode_pin_ctrl;
  localparam int RSTC = 4;

  logic clk = 1'b0;
  logic por = 1'b1, frc = 1'b0, wr = 1'b0, wr_rp = 1'b0, wr_dp = 1'b0;
  logic cap = 1'b0, pa = 1'b1, pb = 1'b1;
  logic [1:0] pa_func;
  logic pa_pu, pb_dbg, pb_pu, ext_req, srst, mode;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rstmode_pin_ctrl #(.RST_CYCLES(RSTC), .SYNC_STAGES(2)) u0 (
    .clk(clk), .por_i(por), .dbg_force_rst_i(frc), .cfg_wr_i(wr),
    .cfg_rstpin_en_i(wr_rp), .cfg_dbgpin_en_i(wr_dp), .tmr_capture_en_i(cap),
    .pin_a_i(pa), .pin_b_i(pb), .pin_a_func_o(pa_func), .pin_a_pullup_o(pa_pu),
    .pin_b_dbg_o(pb_dbg), .pin_b_pullup_o(pb_pu), .ext_rst_req_o(ext_req),
    .sys_rst_o(srst), .mode_bg_o(mode)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_rst_end();
    while (srst) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_por(input logic pb_lvl);
    @(negedge clk);
    pb = pb_lvl; por = 1'b1;
    repeat (2) @(negedge clk);
    por = 1'b0;
    wait_rst_end();
  endtask

  task automatic do_force();
    @(negedge clk); frc = 1'b1;
    @(negedge clk); frc = 1'b0;
    wait_rst_end();
  endtask

  task automatic cfg_write(input logic rp, input logic dp);
    @(negedge clk); wr = 1'b1; wr_rp = rp; wr_dp = dp;
    @(negedge clk); wr = 1'b0; wr_rp = 1'b0; wr_dp = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int n;
    // R10: reset length after power-on release
    @(negedge clk); @(negedge clk);
    chk("R1 reset state pin_b_dbg", pb_dbg, 1);
    por = 1'b0; n = 0;
    while (srst) begin @(negedge clk); n++; end
    chk("R10 reset length", n, RSTC);
    @(negedge clk);
    chk("R1 mode normal", mode, 0);
    chk("R1 pin A gpio", pa_func, 0);
    chk("R1 pin A pullup off", pa_pu, 0);
    chk("R7 pin B pullup after por", pb_pu, 1);

    // R4: pin A low without enable has no effect
    pa = 1'b0;
    n = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); n += ext_req + srst; end
    chk("R4 low pin ignored w/o enable", n, 0);
    pa = 1'b1; repeat (3) @(negedge clk);

    // R6: capture selection
    cap = 1'b1; @(negedge clk); @(negedge clk);
    chk("R6 capture selected", pa_func, 2);
    // R2: enable reset pin
    cfg_write(1'b1, 1'b1);
    chk("R2 pin A reset code", pa_func, 1);
    chk("R2 pin A pullup", pa_pu, 1);
    chk("R6 reset wins over capture", pa_func, 1);
    cap = 1'b0;
    // R3: write zero ignored
    cfg_write(1'b0, 1'b1);
    chk("R3 sticky enable", pa_func, 1);
    // R7: release pin B
    cfg_write(1'b1, 1'b0);
    chk("R7 pin B released", pb_dbg, 0);
    chk("R7 pin B pullup off", pb_pu, 0);

    // R4/R9/R7: external reset keeps normal mode while pin B low
    pb = 1'b0;
    @(negedge clk); pa = 1'b0;
    repeat (2) @(negedge clk);
    chk("R4 no request before 3 clocks", ext_req, 0);
    @(negedge clk);
    chk("R4 request after 3 clocks", ext_req, 1);
    pa = 1'b1;
    @(negedge clk);
    chk("R4 internal reset started", srst, 1);
    wait_rst_end();
    chk("R9 mode kept across pin reset", mode, 0);
    chk("R7 debug enable restored", pb_dbg, 1);
    chk("R3 enable survives pin reset", pa_func, 1);
    pb = 1'b1;

    // R11: write during reset ignored (power-on into normal clears enable)
    do_por(1'b1);
    cfg_write(1'b0, 1'b0);
    chk("R7 write zero releases", pb_dbg, 0);
    @(negedge clk); frc = 1'b1;
    @(negedge clk); frc = 1'b0; wr = 1'b1; wr_rp = 1'b1; wr_dp = 1'b0;
    @(negedge clk); wr = 1'b0; wr_rp = 1'b0;
    wait_rst_end();
    chk("R11 rst enable write ignored", pa_func, 0);
    chk("R11 dbg enable write ignored", pb_dbg, 1);

    // R9: background boot, then pin reset with pin B high keeps background
    do_por(1'b0);
    chk("R5 background mode", mode, 1);
    chk("R5 pin A default reset", pa_func, 1);
    pb = 1'b1;
    @(negedge clk); pa = 1'b0;
    repeat (3) @(negedge clk);
    pa = 1'b1;
    @(negedge clk);
    wait_rst_end();
    chk("R9 background kept", mode, 1);

    // Sweep: source x pin B x capture x prior enable (R5 R8 R12)
    for (int src = 0; src < 2; src++)
      for (int pbl = 0; pbl < 2; pbl++)
        for (int cp = 0; cp < 2; cp++)
          for (int pe = 0; pe < 2; pe++) begin
            int en_exp;
            do_por(1'b1);
            if (pe != 0) cfg_write(1'b1, 1'b0);
            cap = cp[0];
            if (src == 0) begin
              do_por(pbl[0]);
              en_exp = (pbl == 0) ? 1 : 0;
            end else begin
              pb = pbl[0];
              do_force();
              en_exp = pe;
            end
            chk("R8 sampled mode", mode, (pbl == 0) ? 1 : 0);
            chk((src == 0) ? "R5 pin A default" : "R12 enable kept on force",
                pa_func, (en_exp != 0) ? 1 : ((cp != 0) ? 2 : 0));
            chk("R2 pin A pullup follows enable", pa_pu, en_exp);
            chk("R7 pin B debug after reset", pb_dbg, 1);
            pb = 1'b1; cap = 1'b0;
          end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule